// File: doc/BRIEF.md
# Byte-Addressed Up/Down Counter Channel

One counter channel with three 24-bit registers (the running count, a preset and an output latch) that software reaches through two 8-bit ports. A data port moves multi-byte values one byte per access, lowest byte first, and a shared byte pointer steps forward on each access. A write to the control port is a command. Its top three bits pick a target: an immediate reset/load action, the count-mode register, the input/output control register or the index control register. A read of the control port returns a status byte.

The count changes only on single-cycle step pulses from an external decoder, which also gives the direction. Software cannot write the count directly. It fills the preset and then issues a transfer command. To read the count, it snapshots the count into the latch and then reads the latch back byte by byte. Four count modes set what happens at the range edges. Carry and borrow toggle bits extend the usable range by one bit. A selectable one-cycle event pulse reports carries, borrows, compare hits or index pulses. The prescaler byte, the scaling field and the index-control bits are passed out unchanged to the neighbouring decoder and filter logic.

Top module: `ctr_channel`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the count, preset, latch, byte pointer, all flags, all configuration registers, `event_o` and every configuration output. The mode is normal, the scaling is none and the count input is disabled.
- R2: Control-port writes decode bits [7:5] as the target: 000 command, 001 count-mode register (bits [4:0] kept, `quad_scale_o` = bits [4:3]), 010 input/output control (bits [4:0] kept), 011 index control (bits [1:0] kept, driven on `index_cfg_o`). Targets 100 to 111 change nothing.
- R3: Data-port writes fill the preset one byte at a time, starting with the least significant byte. The byte pointer moves on every data-port read or write and wraps to the low byte after the third byte. Command bit 0 (value 0x01) returns the pointer to the low byte.
- R4: Command bits [4:3] = 10 (0x10) copy the count into the latch. Data-port reads return latch byte `ptr`. Command 0x11 resets the pointer and latches in one write. The latch holds its value while the count moves on.
- R5: Command bits [4:3] = 01 (0x08) copy the preset into the count. Command bits [2:1] = 01 (0x02) clear the count. Clear wins over load. Either one overrides a count step in the same cycle.
- R6: In normal mode (count-mode bits [2:1] = 0), the count wraps from 0xFFFFFF to 0 when counting up and from 0 to 0xFFFFFF when counting down. An upward wrap flips the carry toggle (status bit 1). A downward wrap flips the borrow toggle (status bit 0).
- R7: In range-limit mode (1), the count stays at the preset when stepped up from the preset and stays at 0 when stepped down from 0. These edge steps still flip the carry or borrow toggle.
- R8: In modulo-N mode (3), stepping up from the preset gives 0 and stepping down from 0 gives the preset.
- R9: In non-recycle mode (2), a wrap at the full range halts counting until a clear, a preset load or an index load.
- R10: Status bit 5 holds the direction of the last applied step (1 = up). Status bit 4 is the error flag: `noise_err` sets it and command bits [2:1] = 11 (0x06) clear it. Command bits [2:1] = 10 (0x04) clear both toggle bits. All other status bits read 0.
- R11: Step pulses have no effect on the count while input/output control bit 0 is 0.
- R12: When input/output control bit 1 is 0 (active low), an `index_pulse` loads the preset into the count. When bit 1 is 1, `index_pulse` leaves the count unchanged.
- R13: `event_o` pulses for one cycle, in the cycle after the source, for the source picked by input/output control bits [4:3]: 0 carry, 1 compare (an applied step lands on the preset), 2 carry or borrow, 3 index pulse.
- R14: Command bits [4:3] = 11 (0x18) copy the low preset byte to `prescale_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 1 | 0 = data port, 1 = control port |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe; advances the pointer on the data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Latch byte (data port) or status byte (control port) |
| cnt_step | input | 1 | One-cycle count step from the decoder |
| cnt_up | input | 1 | Step direction, 1 = up |
| index_pulse | input | 1 | Qualified index pulse |
| noise_err | input | 1 | Sets the error flag |
| event_o | output | 1 | Selected event pulse |
| prescale_o | output | 8 | Filter prescaler byte |
| quad_scale_o | output | 2 | Scaling field for the decoder |
| index_cfg_o | output | 2 | Index control bits for the decoder |

## Verification
A wrong count only shows at the ports after a latch command followed by three data reads. A bad wrap or halt therefore surfaces at the next snapshot, and the bench takes snapshots right after each edge scenario. A toggle, error or direction bit that goes wrong shows on the very next status read. A wrong event selection shows on `event_o` one cycle after its source. A misplaced byte pointer corrupts the next byte moved, and the bench catches it through reads after deliberate wraps and resets. Status, event and configuration outputs are compared with a behavioural model on every clock.

// File: rtl/ctr_pkg.sv
// Shared types for the counter channel.
// Assumes the control byte layout: [7:5] target, [4:0] payload.
package ctr_pkg;

    localparam logic [2:0] TGT_CMD  = 3'b000;
    localparam logic [2:0] TGT_MODE = 3'b001;
    localparam logic [2:0] TGT_IO   = 3'b010;
    localparam logic [2:0] TGT_IDX  = 3'b011;

    typedef enum logic [1:0] {
        MODE_FREE  = 2'd0,
        MODE_LIMIT = 2'd1,
        MODE_HOLD  = 2'd2,
        MODE_WRAPN = 2'd3
    } cmode_e;

    typedef struct packed {
        logic ptr_rst;
        logic clr_cnt;
        logic clr_flags;
        logic clr_err;
        logic load;
        logic latch;
        logic psc;
    } cmd_t;

endpackage

// File: rtl/ctr_cmd_decode.sv
// Decodes one control-port write into command strobes and
// configuration write enables. Purely combinational.
// Assumes ctl_wr is high for exactly the cycles of a control write.
module ctr_cmd_decode
    import ctr_pkg::*;
(
    input  logic       ctl_wr,
    input  logic [7:0] ctl_byte,
    output cmd_t       cmd,
    output logic       mode_we,
    output logic       io_we,
    output logic       idx_we
);
    logic [2:0] tgt;
    logic       is_cmd;

    assign tgt    = ctl_byte[7:5];
    assign is_cmd = ctl_wr && (tgt == TGT_CMD);

    // Split the target select into write enables
    always_comb begin
        mode_we = ctl_wr && (tgt == TGT_MODE);
        io_we   = ctl_wr && (tgt == TGT_IO);
        idx_we  = ctl_wr && (tgt == TGT_IDX);
    end

    // Orthogonal command fields: [0] pointer, [2:1] clears, [4:3] transfers
    always_comb begin
        cmd.ptr_rst   = is_cmd && ctl_byte[0];
        cmd.clr_cnt   = is_cmd && (ctl_byte[2:1] == 2'd1);
        cmd.clr_flags = is_cmd && (ctl_byte[2:1] == 2'd2);
        cmd.clr_err   = is_cmd && (ctl_byte[2:1] == 2'd3);
        cmd.load      = is_cmd && (ctl_byte[4:3] == 2'd1);
        cmd.latch     = is_cmd && (ctl_byte[4:3] == 2'd2);
        cmd.psc       = is_cmd && (ctl_byte[4:3] == 2'd3);
    end

endmodule

// File: rtl/ctr_port.sv
// Register file of the channel: byte pointer, preset, output latch,
// configuration registers and prescaler byte.
// Assumes CW is a multiple of 8; data reads and writes share one pointer.
module ctr_port
    import ctr_pkg::*;
#(
    parameter int CW    = 24,
    parameter int BYTES = CW / 8,
    parameter int PW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic [7:0]    wr_data,
    input  cmd_t          cmd,
    input  logic          mode_we,
    input  logic          io_we,
    input  logic          idx_we,
    input  logic [CW-1:0] count_i,
    output logic [CW-1:0] preset_o,
    output logic [7:0]    latch_byte_o,
    output logic [4:0]    mode_cfg_o,
    output logic [4:0]    io_cfg_o,
    output logic [1:0]    idx_cfg_o,
    output logic [7:0]    psc_o
);
    localparam logic [PW-1:0] LAST = PW'(BYTES - 1);

    logic [PW-1:0] ptr;
    logic [CW-1:0] latch;
    logic [7:0]    lat_lane [BYTES];

    // Byte pointer: home on command, else step and wrap on data access
    always_ff @(posedge clk) begin
        if (!rst_n)                ptr <= '0;
        else if (cmd.ptr_rst)      ptr <= '0;
        else if (data_wr || data_rd)
            ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
    end

    // Preset: data-port writes land in the lane the pointer names
    always_ff @(posedge clk) begin
        if (!rst_n) preset_o <= '0;
        else if (data_wr) begin
            for (int i = 0; i < BYTES; i++)
                if (ptr == PW'(i)) preset_o[i*8 +: 8] <= wr_data;
        end
    end

    // Output latch: snapshot of the count on the latch command
    always_ff @(posedge clk) begin
        if (!rst_n)         latch <= '0;
        else if (cmd.latch) latch <= count_i;
    end

    // Configuration registers and prescaler byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cfg_o <= '0;
            io_cfg_o   <= '0;
            idx_cfg_o  <= '0;
            psc_o      <= '0;
        end else begin
            if (mode_we) mode_cfg_o <= wr_data[4:0];
            if (io_we)   io_cfg_o   <= wr_data[4:0];
            if (idx_we)  idx_cfg_o  <= wr_data[1:0];
            if (cmd.psc) psc_o      <= preset_o[7:0];
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lat_lane[g] = latch[g*8 +: 8];
    end

    assign latch_byte_o = lat_lane[ptr];

    // R3
    ptr_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.ptr_rst |=> (ptr == '0));

    // R4
    latch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.latch |=> (latch == $past(count_i)));

endmodule

// File: rtl/ctr_core.sv
// Count register, mode handling, toggle/error/direction flags and the
// selected event pulse. Commands take priority over count steps.
// Assumes preset is stable in the cycle it is loaded.
module ctr_core
    import ctr_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cmd_t          cmd,
    input  logic [CW-1:0] preset,
    input  logic [4:0]    mode_cfg,
    input  logic [4:0]    io_cfg,
    input  logic          cnt_step,
    input  logic          cnt_up,
    input  logic          index_pulse,
    input  logic          noise_err,
    output logic [CW-1:0] count_o,
    output logic          bt_o,
    output logic          ct_o,
    output logic          err_o,
    output logic          ud_o,
    output logic          event_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    cmode_e        mode;
    logic          halt, nxt_halt;
    logic          step, idx_load, stepped, carry, borrow, hit;
    logic [CW-1:0] ceil, nxt;

    assign mode     = cmode_e'(mode_cfg[2:1]);
    assign step     = cnt_step && io_cfg[0] && !halt;
    assign idx_load = index_pulse && !io_cfg[1];
    assign ceil     = (mode == MODE_LIMIT || mode == MODE_WRAPN) ? preset : CMAX;

    // Next count: clear, then load, then a mode-dependent step
    always_comb begin
        nxt      = count_o;
        nxt_halt = halt;
        carry    = 1'b0;
        borrow   = 1'b0;
        stepped  = 1'b0;
        if (cmd.clr_cnt) begin
            nxt      = '0;
            nxt_halt = 1'b0;
        end else if (cmd.load || idx_load) begin
            nxt      = preset;
            nxt_halt = 1'b0;
        end else if (step) begin
            stepped = 1'b1;
            if (cnt_up) begin
                if (count_o == ceil) begin
                    carry = 1'b1;
                    nxt   = (mode == MODE_LIMIT) ? count_o : '0;
                    if (mode == MODE_HOLD) nxt_halt = 1'b1;
                end else begin
                    nxt = count_o + CW'(1);
                end
            end else begin
                if (count_o == '0) begin
                    borrow = 1'b1;
                    case (mode)
                        MODE_LIMIT: nxt = '0;
                        MODE_WRAPN: nxt = preset;
                        default:    nxt = CMAX;
                    endcase
                    if (mode == MODE_HOLD) nxt_halt = 1'b1;
                end else begin
                    nxt = count_o - CW'(1);
                end
            end
        end
    end

    assign hit = stepped && (nxt == preset);

    // Count and halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            halt    <= 1'b0;
        end else begin
            count_o <= nxt;
            halt    <= nxt_halt;
        end
    end

    // Flags: toggles, error, direction; clears win over updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bt_o  <= 1'b0;
            ct_o  <= 1'b0;
            err_o <= 1'b0;
            ud_o  <= 1'b0;
        end else begin
            if (cmd.clr_flags) begin
                bt_o <= 1'b0;
                ct_o <= 1'b0;
            end else begin
                bt_o <= bt_o ^ borrow;
                ct_o <= ct_o ^ carry;
            end
            if (cmd.clr_err)     err_o <= 1'b0;
            else if (noise_err)  err_o <= 1'b1;
            if (stepped)         ud_o  <= cnt_up;
        end
    end

    // Event pulse for the source chosen in io_cfg[4:3]
    always_ff @(posedge clk) begin
        if (!rst_n) event_o <= 1'b0;
        else begin
            case (io_cfg[4:3])
                2'd0:    event_o <= carry;
                2'd1:    event_o <= hit;
                2'd2:    event_o <= carry || borrow;
                default: event_o <= index_pulse;
            endcase
        end
    end

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr_cnt |=> (count_o == '0));

    // R7
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LIMIT && cnt_step && io_cfg[0] && cnt_up &&
         count_o == preset && !cmd.clr_cnt && !cmd.load && !idx_load)
        |=> $stable(count_o));

    // R11
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_cfg[0] && !cmd.clr_cnt && !cmd.load && !idx_load)
        |=> $stable(count_o));

    // R6
    carry_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !cmd.clr_flags) |=> (ct_o != $past(ct_o)));

endmodule

// File: rtl/ctr_channel.sv
// Top of the counter channel: control decode, register file and count
// core, plus the read-data multiplexer for the two ports.
// Assumes one access per cycle on the shared port select.
module ctr_channel
    import ctr_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cnt_step,
    input  logic       cnt_up,
    input  logic       index_pulse,
    input  logic       noise_err,
    output logic       event_o,
    output logic [7:0] prescale_o,
    output logic [1:0] quad_scale_o,
    output logic [1:0] index_cfg_o
);
    localparam int BYTES = CW / 8;
    localparam int PW    = (BYTES > 1) ? $clog2(BYTES) : 1;

    cmd_t          cmd;
    logic          mode_we, io_we, idx_we;
    logic [CW-1:0] count, preset;
    logic [7:0]    latch_byte;
    logic [4:0]    mode_cfg, io_cfg;
    logic          bt, ct, err, ud;

    ctr_cmd_decode u_dec (
        .ctl_wr   (port_sel && wr_en),
        .ctl_byte (wr_data),
        .cmd      (cmd),
        .mode_we  (mode_we),
        .io_we    (io_we),
        .idx_we   (idx_we)
    );

    ctr_port #(.CW(CW), .BYTES(BYTES), .PW(PW)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_wr      (!port_sel && wr_en),
        .data_rd      (!port_sel && rd_en),
        .wr_data      (wr_data),
        .cmd          (cmd),
        .mode_we      (mode_we),
        .io_we        (io_we),
        .idx_we       (idx_we),
        .count_i      (count),
        .preset_o     (preset),
        .latch_byte_o (latch_byte),
        .mode_cfg_o   (mode_cfg),
        .io_cfg_o     (io_cfg),
        .idx_cfg_o    (index_cfg_o),
        .psc_o        (prescale_o)
    );

    ctr_core #(.CW(CW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .preset      (preset),
        .mode_cfg    (mode_cfg),
        .io_cfg      (io_cfg),
        .cnt_step    (cnt_step),
        .cnt_up      (cnt_up),
        .index_pulse (index_pulse),
        .noise_err   (noise_err),
        .count_o     (count),
        .bt_o        (bt),
        .ct_o        (ct),
        .err_o       (err),
        .ud_o        (ud),
        .event_o     (event_o)
    );

    assign quad_scale_o = mode_cfg[4:3];

    // Read mux: status byte on the control port, latch lane on data
    always_comb begin
        if (port_sel) rd_data = {2'b00, ud, err, 2'b00, ct, bt};
        else          rd_data = latch_byte;
    end

endmodule

// File: tb/ctr_channel_test.sv
`timescale 1ns/1ps
module ctr_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cnt_step = 1'b0, cnt_up = 1'b0, index_pulse = 1'b0, noise_err = 1'b0;
    logic [7:0] rd_data, prescale_o;
    logic [1:0] quad_scale_o, index_cfg_o;
    logic       event_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ctr_channel uut (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .cnt_step(cnt_step), .cnt_up(cnt_up), .index_pulse(index_pulse),
        .noise_err(noise_err), .event_o(event_o), .prescale_o(prescale_o),
        .quad_scale_o(quad_scale_o), .index_cfg_o(index_cfg_o)
    );

    // ---------------- behavioural reference model ----------------
    localparam int MAXV = 24'hFFFFFF;
    int m_cnt, m_pre, m_lat, m_ptr, m_bt, m_ct, m_e, m_ud, m_halt;
    int m_mode, m_io, m_idx, m_psc, m_ev;
    bit m_live = 0;

    always @(posedge clk) begin : model
        int nc, nh, mode, ceil, car, bor, hit, tgt, code;
        bit ctl, rld, applied;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_lat = 0; m_ptr = 0; m_bt = 0; m_ct = 0;
            m_e = 0; m_ud = 0; m_halt = 0; m_mode = 0; m_io = 0; m_idx = 0;
            m_psc = 0; m_ev = 0; m_live = 1;
        end else begin
            ctl  = port_sel && wr_en;
            tgt  = wr_data / 32;
            code = wr_data % 32;
            rld  = ctl && tgt == 0;
            mode = (m_mode / 2) % 4;
            nc = m_cnt; nh = m_halt; car = 0; bor = 0; hit = 0; applied = 0;
            if (rld && (code / 2) % 4 == 1) begin nc = 0; nh = 0; end
            else if ((rld && (code / 8) == 1) || (index_pulse && (m_io / 2) % 2 == 0)) begin
                nc = m_pre; nh = 0;
            end else if (cnt_step && m_io % 2 == 1 && m_halt == 0) begin
                applied = 1;
                ceil = (mode == 1 || mode == 3) ? m_pre : MAXV;
                if (cnt_up) begin
                    if (m_cnt == ceil) begin
                        car = 1; nc = (mode == 1) ? m_cnt : 0;
                        if (mode == 2) nh = 1;
                    end else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        bor = 1; nc = (mode == 1) ? 0 : (mode == 3) ? m_pre : MAXV;
                        if (mode == 2) nh = 1;
                    end else nc = m_cnt - 1;
                end
                hit = (nc == m_pre);
            end
            case ((m_io / 8) % 4)
                0: m_ev = car;
                1: m_ev = hit;
                2: m_ev = car | bor;
                default: m_ev = index_pulse;
            endcase
            if (rld && (code / 2) % 4 == 2) begin m_bt = 0; m_ct = 0; end
            else begin m_bt = m_bt ^ bor; m_ct = m_ct ^ car; end
            if (rld && (code / 2) % 4 == 3) m_e = 0;
            else if (noise_err) m_e = 1;
            if (applied) m_ud = cnt_up;
            if (rld && code / 8 == 2) m_lat = m_cnt;
            if (rld && code / 8 == 3) m_psc = m_pre % 256;
            if (!port_sel && wr_en) begin
                m_pre = m_pre & ~(255 << (8 * m_ptr));
                m_pre = m_pre | (int'(wr_data) << (8 * m_ptr));
            end
            if (rld && code % 2 == 1) m_ptr = 0;
            else if (!port_sel && (wr_en || rd_en)) m_ptr = (m_ptr == 2) ? 0 : m_ptr + 1;
            if (ctl && tgt == 1) m_mode = code;
            if (ctl && tgt == 2) m_io = code;
            if (ctl && tgt == 3) m_idx = code % 4;
            m_cnt = nc; m_halt = nh;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare against the model on every clock, mid low phase
    always @(negedge clk) begin : monitor
        int exp_rd;
        #1;
        if (m_live && rst_n) begin
            exp_rd = port_sel ? (m_ud * 32 + m_e * 16 + m_ct * 2 + m_bt)
                              : ((m_lat >> (8 * m_ptr)) % 256);
            chk("R4/R10 rd_data vs model", 32'(rd_data), 32'(exp_rd));
            chk("R13 event_o vs model", 32'(event_o), 32'(m_ev));
            chk("R14 prescale_o vs model", 32'(prescale_o), 32'(m_psc));
            chk("R2 quad_scale_o vs model", 32'(quad_scale_o), 32'((m_mode / 8) % 4));
            chk("R2 index_cfg_o vs model", 32'(index_cfg_o), 32'(m_idx));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic s, input logic w, input logic r, input logic [7:0] d,
                         input logic st, input logic up, input logic ix, input logic ne);
        port_sel = s; wr_en = w; rd_en = r; wr_data = d;
        cnt_step = st; cnt_up = up; index_pulse = ix; noise_err = ne;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
            @(negedge clk);
        end
    endtask

    task automatic ctl(input logic [7:0] b);
        drive(1, 1, 0, b, 0, 0, 0, 0);
        @(negedge clk);
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic dwr(input logic [7:0] b);
        drive(0, 1, 0, b, 0, 0, 0, 0);
        @(negedge clk);
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic rd_byte(output logic [7:0] v);
        drive(0, 0, 1, 8'h00, 0, 0, 0, 0);
        #1 v = rd_data;
        @(negedge clk);
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic rd_status(output logic [7:0] v);
        drive(1, 0, 1, 8'h00, 0, 0, 0, 0);
        #1 v = rd_data;
        @(negedge clk);
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic steps(input logic up, input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 0, 8'h00, 1, up, 0, 0);
            @(negedge clk);
        end
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic pulse_index();
        drive(0, 0, 0, 8'h00, 0, 0, 1, 0);
        @(negedge clk);
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic set_preset(input int v);
        ctl(8'h01);
        dwr(v[7:0]); dwr(v[15:8]); dwr(v[23:16]);
    endtask

    task automatic set_count(input int v);
        set_preset(v);
        ctl(8'h08);
    endtask

    task automatic get_count(output int v);
        logic [7:0] b;
        ctl(8'h11);
        v = 0;
        for (int i = 0; i < 3; i++) begin
            rd_byte(b);
            v = v | (int'(b) << (8 * i));
        end
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int c;
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd_status(s);   chk("R1 status after reset", 32'(s), 32'h00);
        chk("R1 event_o after reset", 32'(event_o), 32'h0);
        chk("R1 prescale_o after reset", 32'(prescale_o), 32'h0);
        get_count(c);   chk("R1 count after reset", 32'(c), 32'h0);

        // R2 target decode, upper targets ignored
        ctl(8'h9F); ctl(8'hFF);
        chk("R2 upper target ignored", 32'(quad_scale_o), 32'h0);
        ctl(8'h38);     chk("R2 mode write scale", 32'(quad_scale_o), 32'h3);
        ctl(8'h20);

        // R3 preset bytes LSB first, pointer wrap and home
        set_count(32'h123456);
        get_count(c);   chk("R3 preset byte order", 32'(c), 32'h123456);
        ctl(8'h01); dwr(8'hAA); dwr(8'hBB); dwr(8'hCC); dwr(8'hDD);
        ctl(8'h08);
        get_count(c);   chk("R3 pointer wraps to low byte", 32'(c), 32'hCCBBDD);
        ctl(8'h11); rd_byte(s); ctl(8'h01); rd_byte(s);
        chk("R3 pointer home re-reads low byte", 32'(s), 32'hDD);

        // R14 prescaler and index control outputs
        ctl(8'h18);     chk("R14 prescaler from low preset byte", 32'(prescale_o), 32'hDD);
        ctl(8'h63);     chk("R2 index control bits", 32'(index_cfg_o), 32'h3);
        ctl(8'h60);

        // R11 steps ignored while inputs disabled
        set_count(10);
        steps(1, 3);
        get_count(c);   chk("R11 disabled inputs hold count", 32'(c), 32'd10);

        // R6/R10 normal counting, direction flag
        ctl(8'h43);
        steps(1, 3);
        get_count(c);   chk("R6 count up", 32'(c), 32'd13);
        rd_status(s);   chk("R10 up direction bit", 32'(s), 32'h20);

        // R6 wraps and toggles
        set_count(32'hFFFFFE);
        steps(1, 2);
        get_count(c);   chk("R6 upward wrap to zero", 32'(c), 32'h0);
        rd_status(s);   chk("R6 carry toggle set", 32'(s), 32'h22);
        steps(0, 1);
        get_count(c);   chk("R6 downward wrap to max", 32'(c), 32'hFFFFFF);
        rd_status(s);   chk("R6 borrow toggle set", 32'(s), 32'h03);
        ctl(8'h04);
        rd_status(s);   chk("R10 flag clear command", 32'(s), 32'h00);

        // R10 error flag
        drive(0, 0, 0, 8'h00, 0, 0, 0, 1); @(negedge clk);
        rd_status(s);   chk("R10 error flag set", 32'(s), 32'h10);
        ctl(8'h06);
        rd_status(s);   chk("R10 error flag clear", 32'(s), 32'h00);

        // R7 range-limit
        ctl(8'h22);
        set_count(4);
        steps(1, 2);
        get_count(c);   chk("R7 holds at preset", 32'(c), 32'd4);
        steps(0, 6);
        get_count(c);   chk("R7 holds at zero", 32'(c), 32'd0);

        // R8 modulo-N
        ctl(8'h26);
        steps(0, 1);
        get_count(c);   chk("R8 down from zero to preset", 32'(c), 32'd4);
        steps(1, 1);
        get_count(c);   chk("R8 up from preset to zero", 32'(c), 32'd0);
        steps(1, 3);
        get_count(c);   chk("R8 normal steps", 32'(c), 32'd3);

        // R9 non-recycle
        ctl(8'h24);
        set_count(32'hFFFFFF);
        steps(1, 1);
        get_count(c);   chk("R9 wrap to zero", 32'(c), 32'h0);
        steps(1, 3);
        get_count(c);   chk("R9 halted after wrap", 32'(c), 32'h0);
        ctl(8'h08);
        steps(0, 1);
        get_count(c);   chk("R9 reload restarts counting", 32'(c), 32'hFFFFFE);

        // R12 index load
        ctl(8'h41);
        set_preset(32'h777);
        pulse_index();
        get_count(c);   chk("R12 index loads preset", 32'(c), 32'h777);
        ctl(8'h43);
        set_preset(32'h100);
        pulse_index();
        get_count(c);   chk("R12 index load disabled", 32'(c), 32'h777);

        // R13 event selection
        ctl(8'h5B);
        pulse_index();
        chk("R13 index event", 32'(event_o), 32'h1);
        idle(1);
        chk("R13 event lasts one cycle", 32'(event_o), 32'h0);
        ctl(8'h4B);
        set_preset(32'h779);
        steps(1, 1);
        chk("R13 no compare before preset", 32'(event_o), 32'h0);
        steps(1, 1);
        chk("R13 compare event", 32'(event_o), 32'h1);

        // R5 clear wins over load; load wins over a step
        set_preset(32'h55);
        ctl(8'h0A);
        get_count(c);   chk("R5 clear beats load", 32'(c), 32'h0);
        drive(1, 1, 0, 8'h08, 1, 1, 0, 0); @(negedge clk);
        drive(0, 0, 0, 8'h00, 0, 0, 0, 0);
        get_count(c);   chk("R5 load beats step", 32'(c), 32'h55);

        // R4 latch holds while count moves
        ctl(8'h10);
        steps(1, 2);
        ctl(8'h01);
        c = 0;
        for (int i = 0; i < 3; i++) begin
            rd_byte(s);
            c = c | (int'(s) << (8 * i));
        end
        chk("R4 latch keeps snapshot", 32'(c), 32'h55);

        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule